// File: doc/BRIEF.md
# Host Link Selection Arbiter

This block sits beside several candidate host links during start-up and decides which one the host is actually using. It watches two UART receive paths (each offering a received-byte strobe with its data), a CAN receive-activity strobe, and a USB attach level. Every clock cycle counts as one polling round. The first round that shows qualifying activity fixes the choice. From then on only the chosen link is enabled, and the block reports which one won.

Two of the links, CAN and USB, depend on an external reference clock. When one of them wins, the block compares the reported reference-frequency code with the supported set. If the code is not supported, the block does not enable the link. It raises a system-reset request pulse of fixed length instead and then stays idle until the next reset. The UART links do not depend on the frequency code. Handling the protocol of each link is left to other logic.

Top module: `link_arbiter`

## Requirements
- R1: After reset, `sel_code` is 0, `link_en` is 0 and `sys_reset_req` is 0.
- R2: A high `usb_attach` in any scanning cycle selects USB. The result is code 4 with `link_en[3]`, provided the frequency is supported. USB beats any other activity in the same cycle.
- R3: A UART link qualifies only through a strobe whose byte equals `SYNC_BYTE` (0x7F). A strobe carrying any other byte is ignored, and the outputs stay at 0.
- R4: Among activity in the same cycle, the order is UART1 (code 1, `link_en[0]`), then UART2 (code 2, `link_en[1]`), then CAN (code 3, `link_en[2]`).
- R5: `can_act` selects CAN when no higher-priority activity is present and the frequency is supported.
- R6: Only frequency codes 1, 2 and 3 are supported (8, 14.7456 and 25 MHz). If CAN or USB wins with any other code, `sys_reset_req` is high for exactly `RST_CYCLES` cycles, starting the cycle after the winning cycle. During that time `sel_code` and `link_en` stay 0.
- R7: A UART selection is made whatever the frequency code is.
- R8: Once a link is selected, no later activity on any input changes `sel_code` or `link_en` until reset.
- R9: `link_en` is zero or one-hot, and its set bit always matches `sel_code`.
- R10: After a frequency fault, the block makes no selection until reset.
- R11: Outputs change on the clock edge that samples the winning activity. There are no extra pipeline stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart1_vld | input | 1 | UART1 received-byte strobe |
| uart1_data | input | DATA_W | UART1 received byte |
| uart2_vld | input | 1 | UART2 received-byte strobe |
| uart2_data | input | DATA_W | UART2 received byte |
| can_act | input | 1 | CAN receive frame activity strobe |
| usb_attach | input | 1 | USB cable attach level |
| freq_code | input | FREQ_W | Reference clock frequency code |
| link_en | output | 4 | One-hot link enables |
| sel_code | output | 3 | Selected link: 0 none, 1 UART1, 2 UART2, 3 CAN, 4 USB |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
The hardest case to reach is a CAN or USB win with an unsupported frequency code in the same cycle as lower-priority UART sync bytes. This case must end in a reset pulse, not a fallback to the UART. The bench reaches it by drawing random activity masks together with frequency codes spread over the full code range. It then follows every fault with sync bytes and attach events, to show that nothing is selected afterwards. Noise bytes that never equal the sync value come before each winning cycle.

// File: rtl/larb_pkg.sv
package larb_pkg;
   localparam int NLINK = 4;

   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_UART1 = 3'd1,
      SEL_UART2 = 3'd2,
      SEL_CAN   = 3'd3,
      SEL_USB   = 3'd4
   } sel_e;

   typedef enum logic [1:0] {
      ST_SCAN  = 2'd0,
      ST_LOCK  = 2'd1,
      ST_FAULT = 2'd2
   } st_e;

   // enable bit index per link
   localparam int EN_UART1 = 0;
   localparam int EN_UART2 = 1;
   localparam int EN_CAN   = 2;
   localparam int EN_USB   = 3;
endpackage

// File: rtl/larb_pick.sv
module larb_pick
   import larb_pkg::*;
(
   input  logic [NLINK-1:0] hit,
   output sel_e             pick,
   output logic             any
);
   // fixed polling order inside one round: USB, UART1, UART2, CAN
   always_comb begin
      pick = SEL_NONE;
      if (hit[EN_USB])        pick = SEL_USB;
      else if (hit[EN_UART1]) pick = SEL_UART1;
      else if (hit[EN_UART2]) pick = SEL_UART2;
      else if (hit[EN_CAN])   pick = SEL_CAN;
   end
   assign any = |hit;
endmodule

// File: rtl/larb_freq_chk.sv
module larb_freq_chk #(
   parameter int FREQ_W = 3,
   parameter int N_OK   = 3,
   parameter logic [N_OK*FREQ_W-1:0] OK_LIST = {3'd3, 3'd2, 3'd1}
) (
   input  logic [FREQ_W-1:0] code,
   output logic              ok
);
   logic [N_OK-1:0] match;

   for (genvar g = 0; g < N_OK; g++) begin : g_cmp
      assign match[g] = (code == OK_LIST[g*FREQ_W +: FREQ_W]);
   end

   assign ok = |match;
endmodule

// File: rtl/larb_rst_pulse.sv
module larb_rst_pulse #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic req
);
   localparam int CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LOAD = CW'(LEN);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign req = (cnt != '0);
endmodule

// File: rtl/link_arbiter.sv
module link_arbiter
   import larb_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter logic [DATA_W-1:0] SYNC_BYTE = 'h7F,
   parameter int FREQ_W     = 3,
   parameter int FREQ_OK_A  = 1,
   parameter int FREQ_OK_B  = 2,
   parameter int FREQ_OK_C  = 3,
   parameter int RST_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uart1_vld,
   input  logic [DATA_W-1:0] uart1_data,
   input  logic              uart2_vld,
   input  logic [DATA_W-1:0] uart2_data,
   input  logic              can_act,
   input  logic              usb_attach,
   input  logic [FREQ_W-1:0] freq_code,
   output logic [3:0]        link_en,
   output logic [2:0]        sel_code,
   output logic              sys_reset_req
);
   localparam int NUART = 2;
   localparam int N_OK  = 3;
   localparam logic [N_OK*FREQ_W-1:0] OK_LIST =
      {FREQ_W'(FREQ_OK_C), FREQ_W'(FREQ_OK_B), FREQ_W'(FREQ_OK_A)};

   if (RST_CYCLES < 1) begin : g_bad_len
      $error("RST_CYCLES must be at least 1");
   end
   if (FREQ_W < 2) begin : g_bad_fw
      $error("FREQ_W must hold the supported codes");
   end
   if (NLINK != 4) begin : g_bad_nl
      $error("link count fixed at four");
   end

   logic              uvld [NUART];
   logic [DATA_W-1:0] udat [NUART];
   logic [NUART-1:0]  uhit;

   assign uvld[0] = uart1_vld;
   assign uvld[1] = uart2_vld;
   assign udat[0] = uart1_data;
   assign udat[1] = uart2_data;

   for (genvar g = 0; g < NUART; g++) begin : g_sync
      assign uhit[g] = uvld[g] && (udat[g] == SYNC_BYTE);
   end

   logic [NLINK-1:0] hit;
   assign hit[EN_UART1] = uhit[0];
   assign hit[EN_UART2] = uhit[1];
   assign hit[EN_CAN]   = can_act;
   assign hit[EN_USB]   = usb_attach;

   sel_e pick;
   logic any;
   logic freq_ok;

   larb_pick u_pick (
      .hit  (hit),
      .pick (pick),
      .any  (any)
   );

   larb_freq_chk #(
      .FREQ_W  (FREQ_W),
      .N_OK    (N_OK),
      .OK_LIST (OK_LIST)
   ) u_fchk (
      .code (freq_code),
      .ok   (freq_ok)
   );

   function automatic logic [NLINK-1:0] en_of(sel_e s);
      logic [NLINK-1:0] v;
      v = '0;
      case (s)
         SEL_UART1: v[EN_UART1] = 1'b1;
         SEL_UART2: v[EN_UART2] = 1'b1;
         SEL_CAN:   v[EN_CAN]   = 1'b1;
         SEL_USB:   v[EN_USB]   = 1'b1;
         default:   v = '0;
      endcase
      return v;
   endfunction

   st_e  state;
   sel_e sel_q;
   logic [NLINK-1:0] en_q;
   logic needs_clk;
   logic fault_start;

   assign needs_clk   = (pick == SEL_CAN) || (pick == SEL_USB);
   assign fault_start = (state == ST_SCAN) && any && needs_clk && !freq_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_SCAN;
         sel_q <= SEL_NONE;
         en_q  <= '0;
      end else begin
         case (state)
            ST_SCAN: begin
               if (any) begin
                  if (needs_clk && !freq_ok) begin
                     state <= ST_FAULT;
                  end else begin
                     state <= ST_LOCK;
                     sel_q <= pick;
                     en_q  <= en_of(pick);
                  end
               end
            end
            ST_LOCK:  state <= ST_LOCK;
            ST_FAULT: state <= ST_FAULT;
            default: begin
               state <= ST_SCAN;
               sel_q <= SEL_NONE;
               en_q  <= '0;
            end
         endcase
      end
   end

   larb_rst_pulse #(.LEN(RST_CYCLES)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .start (fault_start),
      .req   (sys_reset_req)
   );

   assign link_en  = en_q;
   assign sel_code = sel_q;
endmodule

// File: rtl/larb_chk.sv
module larb_chk #(
   parameter int DATA_W     = 8,
   parameter logic [DATA_W-1:0] SYNC_BYTE = 'h7F,
   parameter int RST_CYCLES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              uart1_vld,
   input logic [DATA_W-1:0] uart1_data,
   input logic              usb_attach,
   input logic [3:0]        link_en,
   input logic [2:0]        sel_code,
   input logic              sys_reset_req
);
   localparam int HW = $clog2(RST_CYCLES + 2) + 1;
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hi_cnt <= '0;
      else if (sys_reset_req) hi_cnt <= hi_cnt + 1'b1;
   end

   assert_en_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(link_en));

   assert_en_matches_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en[0] == (sel_code == 3'd1)) && (link_en[1] == (sel_code == 3'd2)) &&
      (link_en[2] == (sel_code == 3'd3)) && (link_en[3] == (sel_code == 3'd4)));

   assert_sel_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_code != 3'd0) |=> $stable(sel_code) && $stable(link_en));

   assert_no_sel_in_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> (sel_code == 3'd0) && (link_en == 4'd0));

   assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_cnt <= HW'(RST_CYCLES));

   assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_reset_req) |-> (hi_cnt == HW'(RST_CYCLES)));

   assert_uart1_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en[0]) |-> $past(uart1_vld && (uart1_data == SYNC_BYTE)));

   assert_usb_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en[3]) |-> $past(usb_attach));
endmodule

bind link_arbiter larb_chk #(
   .DATA_W     (DATA_W),
   .SYNC_BYTE  (SYNC_BYTE),
   .RST_CYCLES (RST_CYCLES)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .uart1_vld     (uart1_vld),
   .uart1_data    (uart1_data),
   .usb_attach    (usb_attach),
   .link_en       (link_en),
   .sel_code      (sel_code),
   .sys_reset_req (sys_reset_req)
);

// File: tb/sim_link_arbiter.sv
`timescale 1ns/1ps
module sim_link_arbiter;
   localparam int RST_LEN = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       uart1_vld = 1'b0;
   logic [7:0] uart1_data = 8'h00;
   logic       uart2_vld = 1'b0;
   logic [7:0] uart2_data = 8'h00;
   logic       can_act = 1'b0;
   logic       usb_attach = 1'b0;
   logic [2:0] freq_code = 3'd1;
   logic [3:0] link_en;
   logic [2:0] sel_code;
   logic       sys_reset_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   link_arbiter #(.RST_CYCLES(RST_LEN)) u0 (
      .clk(clk), .rst_n(rst_n),
      .uart1_vld(uart1_vld), .uart1_data(uart1_data),
      .uart2_vld(uart2_vld), .uart2_data(uart2_data),
      .can_act(can_act), .usb_attach(usb_attach), .freq_code(freq_code),
      .link_en(link_en), .sel_code(sel_code), .sys_reset_req(sys_reset_req)
   );

   function automatic int exp_code(logic [3:0] m);
      if (m[3]) return 4;
      if (m[0]) return 1;
      if (m[1]) return 2;
      if (m[2]) return 3;
      return 0;
   endfunction

   function automatic bit freq_good(logic [2:0] f);
      return (f == 3'd1) || (f == 3'd2) || (f == 3'd3);
   endfunction

   function automatic logic [3:0] exp_en(int c);
      if (c == 0) return 4'd0;
      return 4'(1 << (c - 1));
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle();
      uart1_vld = 0; uart2_vld = 0; can_act = 0; usb_attach = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(sel_code == 0 && link_en == 0 && !sys_reset_req, "R1",
            {sel_code, link_en, sys_reset_req}, 0);
   endtask

   function automatic logic [7:0] noise_byte();
      logic [7:0] d;
      d = 8'($urandom);
      if (d == 8'h7F) d = 8'h00;
      return d;
   endfunction

   // apply one cycle of activity given by mask, then check result
   task automatic win(logic [3:0] m, logic [2:0] f, string tag);
      int ec;
      bit flt;
      int cnt;
      uart1_vld = m[0]; uart1_data = m[0] ? 8'h7F : noise_byte();
      uart2_vld = m[1]; uart2_data = m[1] ? 8'h7F : noise_byte();
      can_act = m[2]; usb_attach = m[3]; freq_code = f;
      @(negedge clk);
      idle();
      ec  = exp_code(m);
      flt = (ec >= 3) && !freq_good(f);
      if (flt) begin
         check(sel_code == 0 && link_en == 0, {tag, " R6 no select"}, sel_code, 0);
         check(sys_reset_req == 1, {tag, " R6 req"}, sys_reset_req, 1);
         cnt = 0;
         while (sys_reset_req && cnt < 50) begin
            cnt++;
            @(negedge clk);
         end
         check(cnt == RST_LEN, {tag, " R6 pulse len"}, cnt, RST_LEN);
      end else begin
         check(sel_code == 3'(ec), {tag, " R11 code"}, sel_code, ec);
         check(link_en == exp_en(ec), {tag, " R9 en"}, link_en, exp_en(ec));
         check(!sys_reset_req, {tag, " R7 no req"}, sys_reset_req, 0);
      end
      // later activity must not alter outcome
      for (int k = 0; k < 3; k++) begin
         uart1_vld = 1; uart1_data = 8'h7F; uart2_vld = 1; uart2_data = 8'h7F;
         can_act = 1; usb_attach = 1; freq_code = 3'd2;
         @(negedge clk);
      end
      idle();
      @(negedge clk);
      check(sel_code == (flt ? 3'd0 : 3'(ec)), flt ? "R10 held" : "R8 held",
            sel_code, flt ? 0 : ec);
   endtask

   initial begin
      void'($urandom(32'd1234));
      do_reset();

      // R3: wrong bytes ignored
      for (int k = 0; k < 4; k++) begin
         uart1_vld = 1; uart1_data = 8'h7E + 8'(k == 1 ? 2 : 0);
         uart2_vld = 1; uart2_data = 8'hFF;
         @(negedge clk);
      end
      idle();
      @(negedge clk);
      check(sel_code == 0 && link_en == 0, "R3 noise ignored", sel_code, 0);

      // directed corners
      win(4'b1111, 3'd3, "R2 usb wins");
      do_reset(); win(4'b0011, 3'd0, "R4 uart1 first");
      do_reset(); win(4'b0110, 3'd1, "R4 uart2 over can");
      do_reset(); win(4'b0100, 3'd2, "R5 can");
      do_reset(); win(4'b0100, 3'd5, "R6 can bad");
      do_reset(); win(4'b1001, 3'd7, "R6 usb bad");
      do_reset(); win(4'b0010, 3'd6, "R7 uart bad clk");

      // constrained random
      for (int t = 0; t < 60; t++) begin
         do_reset();
         for (int k = 0; k < int'($urandom_range(0, 4)); k++) begin
            uart1_vld = 1'($urandom); uart1_data = noise_byte();
            uart2_vld = 1'($urandom); uart2_data = noise_byte();
            @(negedge clk);
         end
         idle();
         @(negedge clk);
         check(sel_code == 0, "R3 random noise", sel_code, 0);
         win(4'($urandom_range(1, 15)), 3'($urandom_range(0, 7)), "R4 random");
      end
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule